// File: doc/BRIEF.md
# Synchronous rectifier gate sequencer

This block sequences the two gate drives of a center-tapped synchronous rectifier. Each channel has four digitized comparator flags for its drain-sense voltage: below the pre-trigger level, below the turn-on level, at or above the turn-off level, and above the arming level. The block also takes a per-channel blanking flag from an external half-cycle timer, an enable input and a supply-ramp flag. It drives the two gate outputs, a sense-current-source enable per channel and a latched turn-off threshold select.

Conduction passes from one channel to the other through a single ownership token. The owning channel waits for a pre-trigger edge and turns on its sense current source. It then waits a debounce window before the turn-on flag may fire the gate. The gate turns off on the turn-off flag, which is ignored while blanking is active. Ownership moves to the other channel only when the drain of the channel that turned off rises through the arming level. Because only one channel owns the token at any time, the two gates cannot be high together.

Top module: `sr_gate_seq`

## Requirements
- R1: While reset is asserted, and on leaving it, both gates and both sense enables are low, the threshold select is 0, and no channel owns the token.
- R2: After reset, the first channel to show a rising edge on its pre-trigger flag takes the token, and channel 0 wins a tie. A flag that was already high during reset is not an edge. Once a channel owns the token, pre-trigger edges on the other channel have no effect.
- R3: The owner's sense enable rises on the clock edge that samples its pre-trigger rising edge. It falls on the edge where the gate turns on. It also falls if the pre-trigger flag goes low before turn-on, which returns the channel to armed-idle; a new pre-trigger edge then restarts the debounce.
- R4: The turn-on flag is ignored until the sense enable has been high for DEB_CYC+1 clock edges. With the turn-on flag held high, the gate rises exactly DEB_CYC+1 edges after the sense enable rose.
- R5: After the debounce, the gate turns on at the first edge that samples the turn-on flag high while the pre-trigger flag is still high.
- R6: A conducting gate turns off at the first edge that samples its turn-off flag high with its blanking flag low. While blanking is high, the turn-off flag has no effect.
- R7: After turn-off, the other channel becomes the owner only at a rising edge of the turned-off channel's arming flag. Until then, pre-trigger edges on either channel have no effect.
- R8: The two gate outputs are never high at the same time.
- R9: While enable is low, both gates are low. The sequencing state is kept, so a conducting gate comes back high when enable returns.
- R10: While the ramp flag is high, the threshold select samples the enable input at each clock edge (1 means the -12.5 mV threshold, 0 means the -25 mV threshold). While the ramp flag is low, the select holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable (1 = outputs allowed); also the level sampled for the threshold select |
| ramp_i | input | 1 | Supply is ramping toward its turn-on level |
| pt_i | input | 2 | Per channel: drain sense below the pre-trigger level |
| on_i | input | 2 | Per channel: drain sense below the turn-on threshold |
| off_i | input | 2 | Per channel: drain sense at or above the turn-off threshold |
| arm_i | input | 2 | Per channel: drain sense above the arming level |
| blank_i | input | 2 | Per channel: blanking interval active |
| gate_o | output | 2 | Gate drive requests |
| isrc_o | output | 2 | Sense-current-source enables |
| thr_sel_o | output | 1 | Turn-off threshold select (1 = -12.5 mV, 0 = -25 mV) |

## Verification
The bench targets the simultaneous pre-trigger tie after reset. A design that armed both channels there would raise both sense enables. It counts the debounce edges exactly, so an off-by-one counter shows up as a gate one cycle early or late. It also holds the turn-off flag high under blanking, where a design that ignored blanking would cut conduction short, and it sends pre-trigger edges to the idle channel before the arming hand-off, which a weak interlock would turn into a second live channel. It toggles enable during conduction and after the ramp ends, to catch a gate that leaks through the enable mask or a threshold select that keeps tracking the pin.

// File: rtl/sr_gate_seq.sv
module sr_gate_seq #(
  parameter int DEB_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       ramp_i,
  input  logic [1:0] pt_i,
  input  logic [1:0] on_i,
  input  logic [1:0] off_i,
  input  logic [1:0] arm_i,
  input  logic [1:0] blank_i,
  output logic [1:0] gate_o,
  output logic [1:0] isrc_o,
  output logic       thr_sel_o
);
  localparam int CW = (DEB_CYC < 1) ? 1 : $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(DEB_CYC);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_DEB, S_COND, S_HAND} st_t;

  st_t           st;
  logic          own;
  logic [CW-1:0] cnt;
  logic [1:0]    pt_q, arm_q;

  wire [1:0] pt_rise  = pt_i & ~pt_q;
  wire [1:0] arm_rise = arm_i & ~arm_q;
  wire [1:0] own_vec  = own ? 2'b10 : 2'b01;

  assign gate_o = (st == S_COND && en_i) ? own_vec : 2'b00;
  assign isrc_o = (st == S_DEB) ? own_vec : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      own       <= 1'b0;
      cnt       <= '0;
      pt_q      <= 2'b11;
      arm_q     <= 2'b11;
      thr_sel_o <= 1'b0;
    end else begin
      pt_q  <= pt_i;
      arm_q <= arm_i;
      if (ramp_i) thr_sel_o <= en_i;
      case (st)
        S_IDLE: begin
          if (pt_rise[0]) begin
            own <= 1'b0;
            st  <= S_DEB;
            cnt <= '0;
          end else if (pt_rise[1]) begin
            own <= 1'b1;
            st  <= S_DEB;
            cnt <= '0;
          end
        end
        S_ARM: begin
          if (pt_rise[own]) begin
            st  <= S_DEB;
            cnt <= '0;
          end
        end
        S_DEB: begin
          if (!pt_i[own])                  st  <= S_ARM;
          else if (cnt == CMAX && on_i[own]) st <= S_COND;
          else if (cnt != CMAX)            cnt <= cnt + 1'b1;
        end
        S_COND: begin
          if (off_i[own] && !blank_i[own]) st <= S_HAND;
        end
        S_HAND: begin
          if (arm_rise[own]) begin
            st  <= S_ARM;
            own <= ~own;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sr_gate_seq_chk.sv
module sr_gate_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       ramp_i,
  input logic [1:0] blank_i,
  input logic [1:0] gate_o,
  input logic [1:0] isrc_o,
  input logic       thr_sel_o
);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[0] && gate_o[1]));

  a_r9_enable_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> gate_o == 2'b00);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_i |=> $stable(thr_sel_o));

  for (genvar c = 0; c < 2; c++) begin : g_ch
    a_r3_isrc_off: assert property (@(posedge clk) disable iff (!rst_n)
      gate_o[c] |-> !isrc_o[c]);

    a_r4_debounced: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o[c]) && $past(en_i) |-> $past(isrc_o[c]));

    a_r6_blank_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      $past(gate_o[c] && blank_i[c]) && en_i |-> gate_o[c]);
  end
endmodule

bind sr_gate_seq sr_gate_seq_chk u_chk (.*);

// File: tb/tb_sr_gate_seq.sv
`timescale 1ns/1ps
module tb_sr_gate_seq;
  localparam int DEB = 4;

  logic clk = 0, rst_n = 0;
  logic en_i = 1, ramp_i = 1;
  logic [1:0] pt_i = 0, on_i = 0, off_i = 0, arm_i = 0, blank_i = 0;
  logic [1:0] gate_o, isrc_o;
  logic thr_sel_o;

  int total = 0, bad = 0;
  bit done = 0;

  sr_gate_seq #(.DEB_CYC(DEB)) dut (.*);

  always #5 clk = ~clk;

  // behavioural reference: 0 idle, 1 armed, 2 debounce, 3 conducting, 4 hand-off
  int m_st, m_own, m_age, m_thr;
  logic [1:0] p_pt, p_arm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_own = 0; m_age = 0; m_thr = 0; p_pt = 2'b11; p_arm = 2'b11;
    end else begin
      logic [1:0] ptr, armr;
      ptr  = pt_i & ~p_pt;
      armr = arm_i & ~p_arm;
      if (ramp_i) m_thr = en_i;
      if (m_st == 0) begin
        if (ptr[0]) begin m_own = 0; m_st = 2; m_age = 0; end
        else if (ptr[1]) begin m_own = 1; m_st = 2; m_age = 0; end
      end else if (m_st == 1) begin
        if (ptr[m_own]) begin m_st = 2; m_age = 0; end
      end else if (m_st == 2) begin
        m_age++;
        if (!pt_i[m_own]) m_st = 1;
        else if (m_age > DEB && on_i[m_own]) m_st = 3;
      end else if (m_st == 3) begin
        if (off_i[m_own] && !blank_i[m_own]) m_st = 4;
      end else begin
        if (armr[m_own]) begin m_st = 1; m_own = 1 - m_own; end
      end
      p_pt = pt_i; p_arm = arm_i;
    end
  end

  function automatic logic [1:0] chv(int c);
    return (c == 1) ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 gate", gate_o, (m_st == 3 && en_i) ? chv(m_own) : 2'b00);
    chk("R3 isrc", isrc_o, (m_st == 2) ? chv(m_own) : 2'b00);
    chk("R10 thr", {1'b0, thr_sel_o}, m_thr[1:0]);
    chk("R8 exclusive", {1'b0, gate_o[0] & gate_o[1]}, 2'b00);
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic look(string req, logic [1:0] act, logic [1:0] exp);
    @(negedge clk);
    chk(req, act, exp);
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1: reset state
    chk("R1 gate", gate_o, 2'b00);
    chk("R1 isrc", isrc_o, 2'b00);
    chk("R1 thr", {1'b0, thr_sel_o}, 2'b00);
    rst_n = 1;
    cyc(1);
    // R10: select follows enable during ramp, then holds
    en_i = 0; cyc(1);
    chk("R10 ramp low-pin", {1'b0, thr_sel_o}, 2'b00);
    en_i = 1; cyc(1);
    chk("R10 ramp high-pin", {1'b0, thr_sel_o}, 2'b01);
    ramp_i = 0; en_i = 0; cyc(2);
    chk("R10 hold", {1'b0, thr_sel_o}, 2'b01);
    en_i = 1; cyc(1);
    // R2: tie goes to channel 0
    pt_i = 2'b11; cyc(1);
    chk("R2 tie", isrc_o, 2'b01);
    // R3: pre-trigger loss during debounce
    pt_i = 2'b10; cyc(1);
    chk("R3 abort", isrc_o, 2'b00);
    pt_i = 2'b00; cyc(1);
    pt_i = 2'b10; cyc(2);
    chk("R2 other ignored", isrc_o, 2'b00);
    // R4 / R5: exact debounce count with turn-on held
    on_i = 2'b01; pt_i = 2'b11; cyc(1);
    chk("R4 isrc up", isrc_o, 2'b01);
    cyc(DEB);
    chk("R4 not yet", gate_o, 2'b00);
    cyc(1);
    chk("R5 on", gate_o, 2'b01);
    chk("R3 isrc down", isrc_o, 2'b00);
    // R9: enable masks gate, state kept
    en_i = 0; #1;
    chk("R9 masked", gate_o, 2'b00);
    en_i = 1; #1;
    chk("R9 restored", gate_o, 2'b01);
    // R6: blanking ignores turn-off
    blank_i = 2'b01; off_i = 2'b01; cyc(3);
    chk("R6 blanked", gate_o, 2'b01);
    blank_i = 2'b00; cyc(1);
    chk("R6 off", gate_o, 2'b00);
    // R7: no re-arm before the arming edge
    off_i = 0; on_i = 2'b11; pt_i = 2'b01; cyc(1);
    pt_i = 2'b11; cyc(2);
    chk("R7 wait", isrc_o | gate_o, 2'b00);
    arm_i = 2'b01; cyc(1);
    pt_i = 2'b01; cyc(1);
    pt_i = 2'b11; cyc(1);
    chk("R7 handed", isrc_o, 2'b10);
    cyc(DEB + 1);
    chk("R8 ch1 only", gate_o, 2'b10);
    off_i = 2'b10; cyc(1);
    chk("R6 ch1 off", gate_o, 2'b00);
    off_i = 0; arm_i = 2'b00; cyc(1);
    arm_i = 2'b10; pt_i = 2'b10; cyc(1);
    pt_i = 2'b11; cyc(1);
    look("R7 back to ch0", isrc_o, 2'b01);
    // random traffic checked against the reference every cycle
    for (int i = 0; i < 4000; i++) begin
      pt_i    = 2'($urandom);
      on_i    = 2'($urandom);
      off_i   = 2'($urandom);
      arm_i   = 2'($urandom);
      blank_i = 2'($urandom);
      en_i    = ($urandom % 8) != 0;
      ramp_i  = ($urandom % 16) == 0;
      cyc(1 + ($urandom % 3));
    end
    cyc(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule